// File: doc/BRIEF.md
# Sampling Converter Sequencer and Serial Result Port

This block is the digital side of a 16-bit successive-approximation converter. It watches a read/convert strobe and an active-low chip select, runs each conversion for a fixed number of system cycles, reports progress on a busy flag, and stores every finished result in an output register. A behavioural stand-in for the approximation loop samples a digital code input when the hold phase begins and returns it as the result once the conversion time has passed.

Results leave the block over a one-wire serial data line, most significant bit first. There are two clocking modes. In internal mode the block makes its own data clock. Each conversion start also sends out the previous result. In external mode a host supplies the data clock. A read request produces a one-period sync pulse and then the 16 result bits, followed by the tag input delayed by 16 clocks. This delayed tag lets several converters be chained on one data line. The output code is either straight binary or two's complement. A power-down input blocks new conversions and leaves the stored result untouched.

All control inputs and the external data clock arrive asynchronously. Each passes through a two-stage synchroniser, and edges are detected in the system clock domain.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset, busy_o is high, dclk_o, sdata_o and sync_o are low, and the stored result is 0x0000.
- R2: A conversion starts on a falling edge of the logical OR of rd_conv_in and csel_n_in, with busy_o going low. A falling rd_conv_in while csel_n_in is high starts nothing, and neither does a later fall of csel_n_in while rd_conv_in is high.
- R3: busy_o stays low for exactly CONV_CYCLES system cycles. The result is latched into the output register at the edge where busy_o returns high.
- R4: If rd_conv_in and csel_n_in are both low when busy_o rises, busy_o is high for exactly one cycle. A new conversion then starts and samples code_in at that moment.
- R5: With clk_mode_ext_in low, every conversion start sends the previous result. The transfer uses exactly 16 rising edges on dclk_o, most significant bit first. Each bit is stable while dclk_o is high and changes only as dclk_o falls.
- R6: With clk_mode_ext_in low, dclk_o is low between transfers. sdata_o then holds the tag_in level captured when the conversion started.
- R7: With clk_mode_ext_in high, a read is requested in either of two ways: a rising rd_conv_in while csel_n_in is low, or a falling csel_n_in while rd_conv_in is high. At the next rising xclk_in edge (edge 0), sync_o goes high for one xclk_in period and sdata_o shows bit 15. Edges 1 to 15 present bits 14 down to 0.
- R8: In external mode, from edge 16 on, sdata_o at edge 16+k shows the tag_in level sampled at edge k. This continues while csel_n_in is low and rd_conv_in is high. Raising csel_n_in ends the read, which drives sdata_o low with no further sync pulse.
- R9: The output format is chosen when a transfer is loaded. With straight_in high, the stored code is sent unchanged. With straight_in low, bit 15 is inverted, so 0x8000 is sent as 0x0000, 0xFFFF as 0x7FFF and 0x0000 as 0x8000.
- R10: While pwr_down_in is high, no conversion or internal transfer starts and the stored result is kept. The next transfer after power-down ends therefore carries the result from before power-down.
- R11: An external-mode read issued while a conversion is still running delivers the last completed result, not the one in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_conv_in | input | 1 | Read/convert strobe: fall starts a conversion, rise requests a read in external mode |
| csel_n_in | input | 1 | Active-low chip select, ORed with rd_conv_in |
| pwr_down_in | input | 1 | High blocks new conversions |
| straight_in | input | 1 | High selects straight binary, low two's complement |
| clk_mode_ext_in | input | 1 | High selects the external data clock mode |
| tag_in | input | 1 | Tag bit for idle level and chaining |
| xclk_in | input | 1 | External data clock |
| code_in | input | CODE_W | Code from the approximation stand-in, sampled at hold |
| busy_o | output | 1 | Low while a conversion runs |
| dclk_o | output | 1 | Generated data clock in internal mode |
| sdata_o | output | 1 | Serial data |
| sync_o | output | 1 | Sync pulse ahead of the data in external mode |

## Verification
The hardest condition to reach from the ports is the back-to-back restart of R4. The strobe must be held low across the whole conversion, the code must change during it, and busy must be watched cycle by cycle to see its one-cycle high gap. The bench sets this up directly. It then proves that the restarted conversion sampled the new code by reading the code out on the following transfer. The second hard case is an external read that overlaps a running conversion, the R11 situation. The bench issues it by raising the strobe just after the conversion has started, and checks that busy is still low when the sync edge arrives. The rest of the bench runs randomly chosen codes, formats and tag levels through the internal mode. Each output is compared against a bench function that forms the two's-complement code by subtraction rather than by flipping a bit.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  localparam int SYNC_STAGES = 2;

  // control inputs as they are carried through the synchroniser
  typedef struct packed {
    logic rdc;   // read/convert strobe
    logic csn;   // chip select, active low
    logic pd;    // power down
    logic sb;    // straight binary select
    logic xmode; // external clock mode
    logic tag;   // tag bit
    logic xck;   // external data clock
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  // idle levels: strobe and select high, everything else low
  localparam logic [CTL_W-1:0] CTL_RST = 7'b1100000;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int              W      = 1,
  parameter logic [W-1:0]    RST    = '0,
  parameter int              STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sar_approx_stub.sv
module sar_approx_stub #(
  parameter int CODE_W      = 16,
  parameter int CONV_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic              run_q;
  logic [CW-1:0]     cnt_q;
  logic [CODE_W-1:0] held_q;

  assign done_o = run_q && (cnt_q == '0);
  assign code_o = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      held_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      cnt_q  <= CW'(CONV_CYCLES - 1);
      held_q <= code_i;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_STUB_NOT_INSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o); // R3
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              or_lvl_i,
  input  logic              or_fall_i,
  input  logic              pd_i,
  input  logic              stub_done_i,
  input  logic [CODE_W-1:0] stub_code_i,
  output logic              start_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] result_o
);
  logic              converting_q;
  logic              rearm_q;
  logic [CODE_W-1:0] result_q;

  // new conversion: strobe edge, or strobe still low right at completion
  assign start_o  = !converting_q && !pd_i && (or_fall_i || (rearm_q && !or_lvl_i));
  assign busy_o   = !converting_q;
  assign result_o = result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      converting_q <= 1'b0;
      rearm_q      <= 1'b0;
      result_q     <= '0;
    end else begin
      rearm_q <= stub_done_i;
      if (start_o)          converting_q <= 1'b1;
      else if (stub_done_i) converting_q <= 1'b0;
      if (stub_done_i)      result_q <= stub_code_i;
    end
  end

  AST_START_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !busy_o); // R2
  AST_BUSY_NOT_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |=> !busy_o); // R3
  AST_RESTART_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_q && !or_lvl_i && !pd_i) |=> !busy_o); // R4
  AST_PD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_i && busy_o) |=> busy_o); // R10
  AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !stub_done_i |=> $stable(result_o)); // R10
endmodule

// File: rtl/sar_int_tx.sv
module sar_int_tx #(
  parameter int CODE_W   = 16,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] word_i,
  input  logic              tag_i,
  output logic              dclk_o,
  output logic              sdata_o,
  output logic              active_o
);
  localparam int BW = $clog2(CODE_W);
  localparam int PW = BW + 1;
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic              active_q, ph_q, tag_hold_q;
  logic [HW-1:0]     hcnt_q;
  logic [BW-1:0]     bit_q;
  logic [PW-1:0]     pcnt_q;
  logic [CODE_W-1:0] sreg_q;
  logic              hend_w, finish_w;

  assign hend_w   = (hcnt_q == HW'(HALF_CYC - 1));
  assign finish_w = active_q && ph_q && hend_w && (bit_q == BW'(CODE_W - 1));
  assign dclk_o   = active_q && ph_q;
  assign sdata_o  = active_q ? sreg_q[CODE_W-1] : tag_hold_q;
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      ph_q       <= 1'b0;
      tag_hold_q <= 1'b0;
      hcnt_q     <= '0;
      bit_q      <= '0;
      pcnt_q     <= '0;
      sreg_q     <= '0;
    end else if (load_i) begin
      active_q   <= 1'b1;
      ph_q       <= 1'b0;
      tag_hold_q <= tag_i;
      hcnt_q     <= '0;
      bit_q      <= '0;
      pcnt_q     <= '0;
      sreg_q     <= word_i;
    end else if (active_q) begin
      if (hend_w) begin
        hcnt_q <= '0;
        if (!ph_q) begin
          ph_q   <= 1'b1;
          pcnt_q <= pcnt_q + PW'(1);
        end else begin
          ph_q   <= 1'b0;
          sreg_q <= {sreg_q[CODE_W-2:0], 1'b0};
          if (bit_q == BW'(CODE_W - 1)) active_q <= 1'b0;
          else                          bit_q    <= bit_q + BW'(1);
        end
      end else begin
        hcnt_q <= hcnt_q + HW'(1);
      end
    end
  end

  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |-> (pcnt_q == PW'(CODE_W))); // R5
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && !hend_w && !load_i) |=> $stable(sdata_o)); // R5
endmodule

// File: rtl/sar_ext_tx.sv
module sar_ext_tx #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_i,
  input  logic              xrise_i,
  input  logic              keep_i,
  input  logic [CODE_W-1:0] word_i,
  input  logic              tag_i,
  output logic              sdata_o,
  output logic              sync_o,
  output logic              active_o
);
  // one extra stage so a tag leaves exactly CODE_W clocks after it entered
  logic [CODE_W:0] sreg_q;
  logic            pend_q, active_q, sync_q;

  assign sdata_o  = active_q && sreg_q[CODE_W];
  assign sync_o   = sync_q;
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      if (read_i)                 pend_q <= 1'b1;
      else if (xrise_i && pend_q) pend_q <= 1'b0;

      if (xrise_i && pend_q) begin
        active_q <= 1'b1;
        sync_q   <= 1'b1;
        sreg_q   <= {word_i, tag_i};
      end else if (active_q && !keep_i) begin
        active_q <= 1'b0;
        sync_q   <= 1'b0;
      end else if (xrise_i && active_q) begin
        sync_q <= 1'b0;
        sreg_q <= {sreg_q[CODE_W-1:0], tag_i};
      end
    end
  end

  AST_SYNC_ON_XCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(xrise_i)); // R7
  AST_SYNC_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && xrise_i && !pend_q) |=> !sync_o); // R7
  AST_RELEASE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_i && !pend_q) |=> !active_o); // R8
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int CONV_CYCLES = 80,
  parameter int HALF_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_conv_in,
  input  logic              csel_n_in,
  input  logic              pwr_down_in,
  input  logic              straight_in,
  input  logic              clk_mode_ext_in,
  input  logic              tag_in,
  input  logic              xclk_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              busy_o,
  output logic              dclk_o,
  output logic              sdata_o,
  output logic              sync_o
);
  // two's complement view: flip the sign bit of the offset code
  function automatic logic [CODE_W-1:0] apply_fmt(input logic [CODE_W-1:0] sb_code,
                                                  input logic straight);
    return straight ? sb_code : {~sb_code[CODE_W-1], sb_code[CODE_W-2:0]};
  endfunction

  ctl_t             ctl_raw, ctl_s;
  logic [CTL_W-1:0] ctl_sync;

  assign ctl_raw = {rd_conv_in, csel_n_in, pwr_down_in, straight_in,
                    clk_mode_ext_in, tag_in, xclk_in};

  sar_sync #(.W(CTL_W), .RST(CTL_RST), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_sync));
  assign ctl_s = ctl_t'(ctl_sync);

  // previous-cycle copies for edge detection
  logic rdc_q, csn_q, or_q, xck_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdc_q <= 1'b1;
      csn_q <= 1'b1;
      or_q  <= 1'b1;
      xck_q <= 1'b0;
    end else begin
      rdc_q <= ctl_s.rdc;
      csn_q <= ctl_s.csn;
      or_q  <= ctl_s.rdc | ctl_s.csn;
      xck_q <= ctl_s.xck;
    end
  end

  // named events
  logic or_lvl_w, or_fall_w, xrise_w, ext_read_w, keep_w, start_w, int_load_w;
  assign or_lvl_w   = ctl_s.rdc | ctl_s.csn;
  assign or_fall_w  = or_q && !or_lvl_w;
  assign xrise_w    = ctl_s.xck && !xck_q;
  assign ext_read_w = ctl_s.xmode &&
                      ((ctl_s.rdc && !rdc_q && !ctl_s.csn) ||
                       (csn_q && !ctl_s.csn && ctl_s.rdc));
  assign keep_w     = !ctl_s.csn && ctl_s.rdc;
  assign int_load_w = start_w && !ctl_s.xmode;

  logic              stub_done_w;
  logic [CODE_W-1:0] stub_code_w, result_w, word_w;

  sar_approx_stub #(.CODE_W(CODE_W), .CONV_CYCLES(CONV_CYCLES)) u_stub (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .code_i(code_in),
    .done_o(stub_done_w), .code_o(stub_code_w));

  sar_conv_seq #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .or_lvl_i(or_lvl_w), .or_fall_i(or_fall_w),
    .pd_i(ctl_s.pd), .stub_done_i(stub_done_w), .stub_code_i(stub_code_w),
    .start_o(start_w), .busy_o(busy_o), .result_o(result_w));

  assign word_w = apply_fmt(result_w, ctl_s.sb);

  logic int_dclk_w, int_sdata_w, int_active_w;
  logic ext_sdata_w, ext_sync_w, ext_active_w;

  sar_int_tx #(.CODE_W(CODE_W), .HALF_CYC(HALF_CYC)) u_int_tx (
    .clk(clk), .rst_n(rst_n), .load_i(int_load_w), .word_i(word_w),
    .tag_i(ctl_s.tag), .dclk_o(int_dclk_w), .sdata_o(int_sdata_w),
    .active_o(int_active_w));

  sar_ext_tx #(.CODE_W(CODE_W)) u_ext_tx (
    .clk(clk), .rst_n(rst_n), .read_i(ext_read_w), .xrise_i(xrise_w),
    .keep_i(keep_w), .word_i(word_w), .tag_i(ctl_s.tag),
    .sdata_o(ext_sdata_w), .sync_o(ext_sync_w), .active_o(ext_active_w));

  assign dclk_o  = !ctl_s.xmode && int_dclk_w;
  assign sdata_o = ctl_s.xmode ? ext_sdata_w : int_sdata_w;
  assign sync_o  = ext_sync_w;

  AST_INT_LOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    int_load_w |=> (int_active_w && !busy_o)); // R5
  AST_EXT_NO_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_s.xmode && ext_active_w) |-> !dclk_o); // R7
endmodule

// File: tb/sar_serial_ctrl_tb.sv
`timescale 1ns/1ps
module sar_serial_ctrl_tb_top;
  localparam int CONV = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_conv_in = 1'b1, csel_n_in = 1'b0, pwr_down_in = 1'b0;
  logic straight_in = 1'b1, clk_mode_ext_in = 1'b0, tag_in = 1'b0, xclk_in = 1'b0;
  logic [15:0] code_in = '0;
  logic busy_o, dclk_o, sdata_o, sync_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] last_code = 16'h0000;

  always #4 clk = ~clk;

  sar_serial_ctrl #(.CODE_W(16), .CONV_CYCLES(CONV), .HALF_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_conv_in(rd_conv_in), .csel_n_in(csel_n_in),
    .pwr_down_in(pwr_down_in), .straight_in(straight_in),
    .clk_mode_ext_in(clk_mode_ext_in), .tag_in(tag_in), .xclk_in(xclk_in),
    .code_in(code_in), .busy_o(busy_o), .dclk_o(dclk_o), .sdata_o(sdata_o),
    .sync_o(sync_o));

  // expected output word: two's complement formed by subtracting midscale
  function automatic logic [15:0] exp_word(input logic [15:0] code, input logic sb);
    logic [15:0] r;
    r = sb ? code : 16'(code - 16'd32768);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one internal-mode conversion with transfer capture
  task automatic int_conv(input logic [15:0] code, input logic sb, input logic tg,
                          output logic [15:0] got, output int npulse, output int lowlen);
    logic prevd, seen;
    code_in = code; straight_in = sb; tag_in = tg; clk_mode_ext_in = 1'b0;
    tick(3);
    rd_conv_in = 1'b0;
    got = '0; npulse = 0; lowlen = 0; prevd = 1'b0; seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (dclk_o && !prevd) begin got = {got[14:0], sdata_o}; npulse++; end
      prevd = dclk_o;
      if (!busy_o) begin
        seen = 1'b1; lowlen++;
        if (lowlen == 10) rd_conv_in = 1'b1;
      end else if (seen) break;
    end
    rd_conv_in = 1'b1;
    tag_in = ~tg;
    tick(4);
  endtask

  task automatic xpulse(input logic tg, output logic sd, output logic sy);
    tag_in = tg;
    tick(3);
    xclk_in = 1'b1;
    tick(4);
    sd = sdata_o; sy = sync_o;
    xclk_in = 1'b0;
    tick(1);
  endtask

  task automatic wait_busy(input logic lvl);
    for (int i = 0; i < 400; i++) begin
      if (busy_o == lvl) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] got, cd;
    int np, ll, cnt, dcnt;
    logic sd, sy, sb, tg;
    logic [19:0] tags;
    void'($urandom(32'd4242));

    tick(5);
    chk(busy_o == 1'b1, "R1 busy after reset", busy_o, 1);
    chk(dclk_o == 1'b0 && sync_o == 1'b0, "R1 dclk/sync after reset", {dclk_o, sync_o}, 0);
    chk(sdata_o == 1'b0, "R1 sdata after reset", sdata_o, 0);
    rst_n = 1'b1;
    tick(3);

    // directed internal-mode transfers
    int_conv(16'h1234, 1'b1, 1'b1, got, np, ll);
    chk(got == exp_word(last_code, 1'b1), "R1 R5 first transfer sends reset result", got, exp_word(last_code, 1'b1));
    chk(np == 16, "R5 pulse count", np, 16);
    chk(ll == CONV, "R3 busy low length", ll, CONV);
    chk(sdata_o == 1'b1 && dclk_o == 1'b0, "R6 idle tag level", {dclk_o, sdata_o}, 1);
    last_code = 16'h1234;

    int_conv(16'h8000, 1'b0, 1'b0, got, np, ll);
    chk(got == exp_word(last_code, 1'b0), "R9 twos complement word", got, exp_word(last_code, 1'b0));
    chk(sdata_o == 1'b0, "R6 idle tag low", sdata_o, 0);
    last_code = 16'h8000;
    int_conv(16'hFFFF, 1'b0, 1'b1, got, np, ll);
    chk(got == 16'h0000, "R9 midscale to zero", got, 16'h0000);
    last_code = 16'hFFFF;
    int_conv(16'h0000, 1'b0, 1'b0, got, np, ll);
    chk(got == 16'h7FFF, "R9 full scale", got, 16'h7FFF);
    last_code = 16'h0000;
    int_conv(16'h5A5A, 1'b0, 1'b0, got, np, ll);
    chk(got == 16'h8000, "R9 bottom code", got, 16'h8000);
    last_code = 16'h5A5A;

    // random internal-mode traffic
    for (int k = 0; k < 8; k++) begin
      cd = 16'($urandom); sb = 1'($urandom); tg = 1'($urandom);
      int_conv(cd, sb, tg, got, np, ll);
      chk(got == exp_word(last_code, sb), "R5 R9 random word", got, exp_word(last_code, sb));
      chk(np == 16 && ll == CONV, "R3 R5 random timing", {np[15:0], ll[15:0]}, {16'd16, 16'(CONV)});
      chk(sdata_o == tg && dclk_o == 1'b0, "R6 random idle tag", sdata_o, tg);
      last_code = cd;
    end

    // R2: strobe fall with chip select high starts nothing
    csel_n_in = 1'b1; tick(3);
    rd_conv_in = 1'b0; cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!busy_o) cnt++; end
    rd_conv_in = 1'b1; tick(3);
    csel_n_in = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!busy_o) cnt++; end
    chk(cnt == 0, "R2 no start while deselected", cnt, 0);

    // R2: chip select fall with strobe low starts a conversion
    code_in = 16'hC3A1; straight_in = 1'b1;
    csel_n_in = 1'b1; tick(3);
    rd_conv_in = 1'b0; tick(3);
    csel_n_in = 1'b0;
    tick(6);
    chk(busy_o == 1'b0, "R2 start on select fall", busy_o, 0);
    rd_conv_in = 1'b1;
    wait_busy(1'b1);
    tick(4);
    last_code = 16'hC3A1;

    // R10: power down blocks conversions and transfers
    pwr_down_in = 1'b1; code_in = 16'h0F0F; tick(4);
    rd_conv_in = 1'b0; cnt = 0; dcnt = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!busy_o) cnt++;
      if (dclk_o) dcnt++;
      if (i == 20) rd_conv_in = 1'b1;
    end
    chk(cnt == 0 && dcnt == 0, "R10 no activity in power down", {cnt[15:0], dcnt[15:0]}, 0);
    pwr_down_in = 1'b0; tick(4);
    int_conv(16'h2468, 1'b1, 1'b0, got, np, ll);
    chk(got == 16'hC3A1, "R10 result retained", got, 16'hC3A1);
    last_code = 16'h2468;

    // R4: strobe held low across completion
    code_in = 16'hAAAA; straight_in = 1'b1; tick(3);
    rd_conv_in = 1'b0;
    wait_busy(1'b0);
    tick(5);
    code_in = 16'h1357;
    wait_busy(1'b1);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (!busy_o) break;
      cnt++;
      @(negedge clk);
    end
    rd_conv_in = 1'b1;
    chk(cnt == 1, "R4 one-cycle busy gap", cnt, 1);
    wait_busy(1'b1);
    tick(4);
    int_conv(16'h0001, 1'b1, 1'b0, got, np, ll);
    chk(got == 16'h1357, "R4 restart sampled new code", got, 16'h1357);
    last_code = 16'h0001;

    // external mode, read issued while converting
    clk_mode_ext_in = 1'b1; straight_in = 1'b1; code_in = 16'hBEEF; tick(4);
    rd_conv_in = 1'b0; tick(6);
    chk(busy_o == 1'b0, "R2 ext-mode start", busy_o, 0);
    rd_conv_in = 1'b1; tick(4);
    for (int k = 0; k < 20; k++) tags[k] = 1'($urandom);
    got = '0; dcnt = 0;
    for (int k = 0; k < 20; k++) begin
      xpulse(tags[k], sd, sy);
      if (dclk_o) dcnt++;
      if (k == 0) begin
        chk(sy == 1'b1, "R7 sync at first edge", sy, 1);
        chk(busy_o == 1'b0, "R11 read overlaps conversion", busy_o, 0);
      end else begin
        chk(sy == 1'b0, "R7 sync one period", sy, 0);
      end
      if (k < 16) got = {got[14:0], sd};
      else chk(sd == tags[k-16], "R8 delayed tag", sd, tags[k-16]);
    end
    chk(got == exp_word(last_code, 1'b1), "R11 previous result read", got, exp_word(last_code, 1'b1));
    chk(dcnt == 0, "R7 no generated clock in ext mode", dcnt, 0);
    csel_n_in = 1'b1; tick(4);
    chk(sdata_o == 1'b0, "R8 release drives data low", sdata_o, 0);
    xpulse(1'b1, sd, sy);
    chk(sd == 1'b0 && sy == 1'b0, "R8 no output after release", {sd, sy}, 0);
    wait_busy(1'b1);
    tick(4);
    last_code = 16'hBEEF;

    // external mode, read after completion via select fall, two's complement
    straight_in = 1'b0; tick(3);
    csel_n_in = 1'b0; tick(4);
    got = '0;
    for (int k = 0; k < 16; k++) begin
      xpulse(1'b0, sd, sy);
      if (k == 0) chk(sy == 1'b1, "R7 sync on select-fall read", sy, 1);
      got = {got[14:0], sd};
    end
    chk(got == exp_word(last_code, 1'b0), "R7 R9 select-fall read word", got, exp_word(last_code, 1'b0));
    chk(busy_o == 1'b1, "R2 select fall with strobe high no start", busy_o, 1);
    csel_n_in = 1'b1; tick(4);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule